// File: doc/BRIEF.md
# Two-Speed Start-up Clock Controller

This block picks the core clock source after a reset and after a wake-up from sleep. When a crystal-type primary oscillator is configured and the two-speed option is on, the core first runs from the internal oscillator. The block counts primary oscillator ticks until the oscillator is stable, adds a lock wait when a PLL follows the crystal, and then hands the core over to the primary clock. It then sets a status bit and raises a one-cycle ready strobe. Software may request sleep or change the clock source while the wait is in progress, and the block honours either request.

All logic runs in a single reference clock domain. The clock choice appears as a synchronous select level. Primary oscillator cycles arrive as single-cycle tick pulses that have already been synchronised into that domain.

The controller is one state machine with seven states:
- `ST_LAUNCH` decides the path.
- `ST_OST` counts oscillator start-up ticks.
- `ST_PLL` waits for PLL lock in reference cycles.
- `ST_SWITCH` waits out the changeover ticks.
- `ST_PRIMARY` runs from the primary clock.
- `ST_HOLD` stays on the internal clock after an abort.
- `ST_SLEEP` is the sleep state.

Transitions:
- Reset enters `ST_LAUNCH`.
- `ST_LAUNCH` goes to `ST_OST` when the feature applies, and to `ST_PRIMARY` otherwise.
- `ST_OST` goes to `ST_PLL` (PLL mode) or to `ST_SWITCH` when the start-up count is reached.
- `ST_PLL` goes to `ST_SWITCH` when the lock wait ends.
- `ST_SWITCH` goes to `ST_PRIMARY` after the changeover ticks.
- `ST_OST` and `ST_PLL` go to `ST_HOLD` on a source change.
- Every state other than `ST_SLEEP` goes to `ST_SLEEP` on a sleep request.
- `ST_SLEEP` goes to `ST_LAUNCH` on a wake event.

Top module: `tss_clock_ctrl`

## Requirements
- R1: While `rst_n` is low, `use_primary`, `pri_active` and `ready` are 0. After release, the start-up sequence begins as for a wake-up.
- R2: `osc_mode` codes 0 (low-power crystal), 1 (crystal), 2 (high-speed crystal) and 3 (high-speed crystal with PLL) are the crystal modes. Codes 4 to 7 are non-crystal modes. The two-speed sequence applies only when `cfg_two_speed` is 1 and the mode is a crystal mode.
- R3: When the sequence applies, `use_primary` stays 0 (internal clock) until at least OST_TICKS primary ticks have been seen.
- R4: In crystal modes without PLL, the switch to primary follows OST_TICKS primary ticks and then SWITCH_TICKS further primary ticks, plus at most four reference cycles of state overhead.
- R5: In PLL mode, PLL_WAIT_CYCLES reference cycles are inserted between the start-up count and the changeover.
- R6: When the sequence does not apply, `use_primary` and `pri_active` become 1 within two cycles of the start event, with a ready pulse.
- R7: `ready` is a single-cycle pulse in the cycle `use_primary` rises. `pri_active` is 1 whenever `use_primary` is 1.
- R8: `sleep_req` in any state other than sleep drives `use_primary` and `pri_active` to 0 in the next cycle, and they stay 0 until `wake_evt`. The wake event restarts the sequence.
- R9: `src_change` during the start-up count or the PLL wait aborts the switch. The block stays on the internal clock with no ready pulse until sleep then wake, or reset.
- R10: Once the primary clock is active, `src_change` and `wake_evt` have no effect. Only `sleep_req` leaves that state.
- R11: With no primary ticks, the block never leaves the internal clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_speed | input | 1 | Two-speed start-up enable configuration |
| osc_mode | input | 3 | Primary oscillator mode code |
| wake_evt | input | 1 | Wake-up from sleep pulse |
| sleep_req | input | 1 | Sleep entry request pulse |
| src_change | input | 1 | Software clock-source change pulse |
| pri_tick | input | 1 | One pulse per primary oscillator cycle |
| use_primary | output | 1 | Clock select: 1 primary, 0 internal |
| pri_active | output | 1 | Status: primary clock drives the core |
| ready | output | 1 | One-cycle strobe when the primary takes over |

## Verification
The hand-over latency is measured with primary ticks on every cycle, with ticks on every other cycle, and with no ticks at all. Comparing these runs separates counting primary ticks from counting reference cycles, and shows that a dead oscillator is never selected. A PLL mode, a plain crystal mode, a non-crystal mode with the enable set, and a crystal mode with the enable cleared are each started. These runs tell apart the lock wait, the start-up wait, and the direct path. Sleep and source-change pulses are applied during the start-up count, during the PLL wait, and after the primary is active, which shows where each is honoured, aborts the switch, or is ignored.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [2:0] {
        ST_LAUNCH  = 3'd0,
        ST_OST     = 3'd1,
        ST_PLL     = 3'd2,
        ST_SWITCH  = 3'd3,
        ST_PRIMARY = 3'd4,
        ST_HOLD    = 3'd5,
        ST_SLEEP   = 3'd6
    } tss_state_e;

    localparam logic [2:0] MODE_LPXTAL = 3'd0;
    localparam logic [2:0] MODE_XTAL   = 3'd1;
    localparam logic [2:0] MODE_HSXTAL = 3'd2;
    localparam logic [2:0] MODE_HSPLL  = 3'd3;

endpackage

// File: rtl/tss_mode_decode.sv
module tss_mode_decode
    import tss_pkg::*;
(
    input  logic [2:0] osc_mode,
    output logic       is_crystal,
    output logic       needs_pll
);

    always_comb begin
        is_crystal = (osc_mode == MODE_LPXTAL) || (osc_mode == MODE_XTAL) ||
                     (osc_mode == MODE_HSXTAL) || (osc_mode == MODE_HSPLL);
        needs_pll  = (osc_mode == MODE_HSPLL);
    end

endmodule

// File: rtl/tss_event_counter.sv
module tss_event_counter #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (inc && (count_q != LIM)) begin
            count_q <= count_q + CW'(1);
        end
    end

    assign done = (count_q == LIM);

endmodule

// File: rtl/tss_clock_ctrl.sv
module tss_clock_ctrl
    import tss_pkg::*;
#(
    parameter int unsigned OST_TICKS       = 1024,
    parameter int unsigned PLL_WAIT_CYCLES = 16000,
    parameter int unsigned SWITCH_TICKS    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_two_speed,
    input  logic [2:0] osc_mode,
    input  logic       wake_evt,
    input  logic       sleep_req,
    input  logic       src_change,
    input  logic       pri_tick,
    output logic       use_primary,
    output logic       pri_active,
    output logic       ready
);

    tss_state_e state_q, state_n;
    logic is_crystal, needs_pll, feature_on;
    logic ost_done, pll_done, sw_done;
    logic use_primary_q, pri_active_q, ready_q;

    tss_mode_decode u_decode (
        .osc_mode   (osc_mode),
        .is_crystal (is_crystal),
        .needs_pll  (needs_pll)
    );

    assign feature_on = cfg_two_speed && is_crystal;

    tss_event_counter #(.LIMIT(OST_TICKS)) u_ost_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_OST),
        .inc   (pri_tick),
        .done  (ost_done)
    );

    generate
        if (PLL_WAIT_CYCLES == 0) begin : g_no_pll_wait
            assign pll_done = 1'b1;
        end else begin : g_pll_wait
            tss_event_counter #(.LIMIT(PLL_WAIT_CYCLES)) u_pll_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (state_q != ST_PLL),
                .inc   (1'b1),
                .done  (pll_done)
            );
        end
    endgenerate

    tss_event_counter #(.LIMIT(SWITCH_TICKS)) u_sw_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_SWITCH),
        .inc   (pri_tick),
        .done  (sw_done)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_LAUNCH:  state_n = feature_on ? ST_OST : ST_PRIMARY;
            ST_OST: begin
                if (src_change)    state_n = ST_HOLD;
                else if (ost_done) state_n = needs_pll ? ST_PLL : ST_SWITCH;
            end
            ST_PLL: begin
                if (src_change)    state_n = ST_HOLD;
                else if (pll_done) state_n = ST_SWITCH;
            end
            ST_SWITCH:  if (sw_done) state_n = ST_PRIMARY;
            ST_PRIMARY: state_n = ST_PRIMARY;
            ST_HOLD:    state_n = ST_HOLD;
            ST_SLEEP:   if (wake_evt) state_n = ST_LAUNCH;
            default:    state_n = ST_LAUNCH;
        endcase
        if (sleep_req && (state_q != ST_SLEEP)) begin
            state_n = ST_SLEEP;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LAUNCH;
        else        state_q <= state_n;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_primary_q <= 1'b0;
            pri_active_q  <= 1'b0;
            ready_q       <= 1'b0;
        end else begin
            use_primary_q <= (state_n == ST_PRIMARY);
            pri_active_q  <= (state_n == ST_PRIMARY);
            ready_q       <= (state_n == ST_PRIMARY) && (state_q != ST_PRIMARY);
        end
    end

    assign use_primary = use_primary_q;
    assign pri_active  = pri_active_q;
    assign ready       = ready_q;

endmodule

// File: rtl/tss_clock_ctrl_chk.sv
module tss_clock_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic use_primary,
    input logic pri_active,
    input logic ready
);

    // R7
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R7
    ready_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_primary) |-> ready);

    // R7
    status_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_primary |-> pri_active);

    // R8
    sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (!use_primary && !pri_active));

    // R10
    primary_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_primary && !sleep_req) |=> use_primary);

endmodule

bind tss_clock_ctrl tss_clock_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .use_primary (use_primary),
    .pri_active  (pri_active),
    .ready       (ready)
);

// File: tb/tss_clock_ctrl_tb.sv
module tss_clock_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int OST = 16;
    localparam int PLLW = 20;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_two_speed = 1'b0;
    logic [2:0] osc_mode = 3'd0;
    logic wake_evt = 1'b0;
    logic sleep_req = 1'b0;
    logic src_change = 1'b0;
    logic pri_tick = 1'b0;
    logic use_primary, pri_active, ready;

    int tick_mode = 0;
    int cycle = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        string tag;
        int lo;
        int hi;
        int t0;
    } exp_t;
    exp_t sb_q[$];

    tss_clock_ctrl #(
        .OST_TICKS(OST), .PLL_WAIT_CYCLES(PLLW), .SWITCH_TICKS(SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_two_speed(cfg_two_speed),
        .osc_mode(osc_mode), .wake_evt(wake_evt), .sleep_req(sleep_req),
        .src_change(src_change), .pri_tick(pri_tick),
        .use_primary(use_primary), .pri_active(pri_active), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    // primary tick source
    initial begin
        forever begin
            @(negedge clk);
            if (tick_mode == 1)      pri_tick = 1'b1;
            else if (tick_mode == 2) pri_tick = ~pri_tick;
            else                     pri_tick = 1'b0;
        end
    end

    task automatic chk(string tag, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic expect_ready(string tag, int lo, int hi);
        exp_t e;
        e.tag = tag; e.lo = lo; e.hi = hi; e.t0 = cycle;
        sb_q.push_back(e);
    endtask

    // monitor: pops expected hand-overs and compares latency
    always @(negedge clk) begin
        if (rst_n && ready) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected ready actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if ((cycle - e.t0) < e.lo || (cycle - e.t0) > e.hi) begin
                    errors++;
                    $display("FAIL %s latency actual %0d expected %0d..%0d",
                             e.tag, cycle - e.t0, e.lo, e.hi);
                end
            end
        end else if (sb_q.size() > 0 && (cycle - sb_q[0].t0) > sb_q[0].hi) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s no ready actual %0d expected %0d..%0d",
                     e.tag, cycle - e.t0, e.lo, e.hi);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_reset(logic [2:0] mode, logic en, int tmode);
        @(negedge clk);
        rst_n = 1'b0;
        osc_mode = mode;
        cfg_two_speed = en;
        tick_mode = tmode;
        wait_cyc(2);
        chk("R1 reset use_primary", use_primary, 1'b0);
        chk("R1 reset pri_active", pri_active, 1'b0);
        chk("R1 reset ready", ready, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic pulse_wake(bit push, string tag, int lo, int hi);
        @(negedge clk);
        wake_evt = 1'b1;
        if (push) expect_ready(tag, lo, hi);
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_src();
        @(negedge clk);
        src_change = 1'b1;
        @(negedge clk);
        src_change = 1'b0;
    endtask

    initial begin
        // plain crystal, ticks every cycle
        start_reset(3'd1, 1'b1, 1);
        expect_ready("R4", OST + SW, OST + SW + 4);
        wait_cyc(5);
        chk("R3 internal during start-up", use_primary, 1'b0);
        wait_cyc(25);
        chk("R4 primary selected", use_primary, 1'b1);
        chk("R7 status set", pri_active, 1'b1);

        // PLL mode
        start_reset(3'd3, 1'b1, 1);
        expect_ready("R5", OST + PLLW + SW, OST + PLLW + SW + 6);
        wait_cyc(25);
        chk("R5 still internal during lock wait", use_primary, 1'b0);
        wait_cyc(25);
        chk("R5 primary after lock wait", use_primary, 1'b1);

        // non-crystal mode with enable set
        start_reset(3'd5, 1'b1, 1);
        expect_ready("R2 non-crystal direct", 1, 2);
        wait_cyc(4);
        chk("R6 direct primary", use_primary, 1'b1);
        chk("R6 direct status", pri_active, 1'b1);

        // crystal mode with enable cleared
        start_reset(3'd2, 1'b0, 1);
        expect_ready("R6 disabled direct", 1, 2);
        wait_cyc(4);
        chk("R6 disabled primary", use_primary, 1'b1);

        // dead primary oscillator
        start_reset(3'd0, 1'b1, 0);
        wait_cyc(100);
        chk("R11 stays internal", use_primary, 1'b0);
        chk("R11 status clear", pri_active, 1'b0);

        // ticks every other cycle
        start_reset(3'd2, 1'b1, 2);
        expect_ready("R4 half-rate ticks", 2 * (OST + SW), 2 * (OST + SW) + 8);
        wait_cyc(20);
        chk("R4 half-rate still internal", use_primary, 1'b0);
        wait_cyc(40);
        chk("R4 half-rate primary", use_primary, 1'b1);

        // ignored inputs while primary
        pulse_src();
        pulse_wake(1'b0, "", 0, 0);
        wait_cyc(3);
        chk("R10 primary kept", use_primary, 1'b1);
        chk("R10 status kept", pri_active, 1'b1);

        // sleep from primary, then wake
        pulse_sleep();
        chk("R8 sleep drops select", use_primary, 1'b0);
        chk("R8 sleep drops status", pri_active, 1'b0);
        tick_mode = 1;
        wait_cyc(30);
        chk("R8 stays asleep", use_primary, 1'b0);
        pulse_wake(1'b1, "R8 wake restart", OST + SW, OST + SW + 5);
        wait_cyc(30);
        chk("R8 primary after wake", use_primary, 1'b1);

        // sleep during start-up count
        start_reset(3'd1, 1'b1, 1);
        wait_cyc(5);
        pulse_sleep();
        chk("R8 sleep aborts start-up", use_primary, 1'b0);
        wait_cyc(40);
        chk("R8 no switch while asleep", use_primary, 1'b0);

        // source change during start-up count
        pulse_wake(1'b0, "", 0, 0);
        wait_cyc(6);
        pulse_src();
        wait_cyc(60);
        chk("R9 abort keeps internal", use_primary, 1'b0);
        chk("R9 abort status clear", pri_active, 1'b0);
        pulse_sleep();
        pulse_wake(1'b1, "R9 recover via wake", OST + SW, OST + SW + 5);
        wait_cyc(30);
        chk("R9 recovered", use_primary, 1'b1);

        // source change during PLL wait
        start_reset(3'd3, 1'b1, 1);
        wait_cyc(25);
        pulse_src();
        wait_cyc(50);
        chk("R9 PLL abort internal", use_primary, 1'b0);

        wait_cyc(5);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R7 pending ready actual %0d expected 0", sb_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule